// File: doc/BRIEF.md
# Light-Load Gate Suspend Detector

This block decides, separately for each rectifier channel, when gate driving should be suspended because the converter is running lightly loaded. A neighbouring timing block reports the conduction time of each switching cycle. It sends this as a one-clock valid strobe with a value in clock ticks. This block compares each report against a threshold. The threshold depends on the frequency range, which a one-bit range select picks. The block raises a per-channel gate-disable flag once the cycles turn consistently short, and drops the flag once they turn consistently long again.

The flag does not toggle on a single odd cycle, because each direction needs an unbroken run of qualifying cycles (seven by default). A second path watches the raw level of the low-detect comparator. If that level stays high for a long time, as it does between bursts when the converter skips cycles, the channel is suspended at once. The same run rule then returns it to normal driving once switching resumes.

Top module: `lgm_detector`

## Requirements
- R1: After reset every bit of `gate_off` is 0 (normal driving), and all run and idle counts start from zero.
- R2: `hf_sel` = 0 selects the low-frequency threshold `LF_THR` (default 750 ticks, 3.75 us at 200 MHz). `hf_sel` = 1 selects `HF_THR` (default 380 ticks, 1.90 us). A measurement is short when `cond_time` < threshold and long when it is greater than or equal to the threshold.
- R3: While a channel is driving, `RUN_LEN` (default 7) consecutive short measurements set its `gate_off`. The flag is set on the clock edge that samples the last of them.
- R4: While driving, a long measurement restarts the entry run, so a full `RUN_LEN` more short measurements are needed.
- R5: While suspended, `RUN_LEN` consecutive long measurements clear `gate_off`. The flag is cleared on the clock edge that samples the last of them.
- R6: While suspended, a short measurement restarts the exit run.
- R7: When `det_high` of a channel is sampled high on `IDLE_CYC` consecutive clock edges (default 4800, 24 us), `gate_off` is set on the last of those edges. A low sample restarts the count.
- R8: A suspension entered through the idle path is left through the same `RUN_LEN` long-measurement rule as in R5.
- R9: Channels are independent: the inputs of one channel never change the flag of another.
- R10: Clock edges with neither `cond_valid` nor `det_high` asserted for a channel leave its flag and its run count unchanged. Gaps between measurements neither advance nor break a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hf_sel | input | 1 | Frequency range select: 0 low range, 1 high range |
| cond_valid | input | NUM_CH | Per-channel strobe: a new conduction time is present this cycle |
| cond_time | input | NUM_CH x TW | Per-channel conduction time of the last switching cycle, in clock ticks |
| det_high | input | NUM_CH | Per-channel level of the low-detect comparator (1 = drain voltage high) |
| gate_off | output | NUM_CH | Per-channel gate-disable flag |

## Verification
The bench aims at the edges of the run rule. It checks that the sixth qualifying cycle is not enough and the seventh is. It checks that a value exactly equal to the threshold counts as long. A design that compared the wrong way would suspend or resume one cycle type off, and an off-by-one counter would switch a measurement early or late. A single breaking cycle placed mid-run must restart the count, while idle gaps between strobes must not. A design that confused these would either suspend on a scattered mix of cycles or never suspend at a slow report rate. The idle timer is probed one edge short of its limit and after a one-cycle dropout, so a timer that fired early or failed to restart would show up at once. A final check confirms that the other channel stays put throughout.

// File: rtl/lgm_pkg.sv
package lgm_pkg;

    typedef enum logic {
        LGM_DRIVE   = 1'b0,
        LGM_SUSPEND = 1'b1
    } lgm_state_e;

endpackage

// File: rtl/lgm_thresh_sel.sv
module lgm_thresh_sel #(
    parameter int TW     = 12,
    parameter int LF_THR = 750,
    parameter int HF_THR = 380
) (
    input  logic          hf_sel,
    output logic [TW-1:0] thr
);
    localparam logic [TW-1:0] LF_V = TW'(LF_THR);
    localparam logic [TW-1:0] HF_V = TW'(HF_THR);

    always_comb begin
        thr = hf_sel ? HF_V : LF_V;
    end
endmodule

// File: rtl/lgm_idle_timer.sv
module lgm_idle_timer #(
    parameter int IDLE_CYC = 4800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_high,
    output logic fire
);
    localparam int IW = $clog2(IDLE_CYC + 1);
    localparam logic [IW-1:0] LIMIT = IW'(IDLE_CYC);
    localparam logic [IW-1:0] LAST  = IW'(IDLE_CYC - 1);

    typedef struct packed {
        logic [IW-1:0] cnt;
    } idle_st_t;

    idle_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (!det_high) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
            fire     = (st_q.cnt == LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lgm_run_fsm.sv
module lgm_run_fsm
    import lgm_pkg::*;
#(
    parameter int TW      = 12,
    parameter int RUN_LEN = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          meas_valid,
    input  logic [TW-1:0] meas_time,
    input  logic [TW-1:0] thr,
    input  logic          idle_fire,
    output logic          gate_off
);
    localparam int RW = $clog2(RUN_LEN + 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);

    typedef struct packed {
        lgm_state_e    state;
        logic [RW-1:0] run;
    } run_st_t;

    run_st_t st_d, st_q;
    logic    is_short;
    logic    qualifies;

    always_comb begin
        st_d      = st_q;
        is_short  = (meas_time < thr);
        qualifies = (st_q.state == LGM_DRIVE) ? is_short : !is_short;
        if (idle_fire) begin
            st_d.state = LGM_SUSPEND;
            st_d.run   = '0;
        end else if (meas_valid) begin
            if (!qualifies) begin
                st_d.run = '0;
            end else if (st_q.run == RUN_LAST) begin
                st_d.state = (st_q.state == LGM_DRIVE) ? LGM_SUSPEND : LGM_DRIVE;
                st_d.run   = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: LGM_DRIVE, run: '0};
        else        st_q <= st_d;
    end

    assign gate_off = (st_q.state == LGM_SUSPEND);
endmodule

// File: rtl/lgm_detector.sv
module lgm_detector #(
    parameter int NUM_CH   = 2,
    parameter int TW       = 12,
    parameter int LF_THR   = 750,
    parameter int HF_THR   = 380,
    parameter int RUN_LEN  = 7,
    parameter int IDLE_CYC = 4800
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hf_sel,
    input  logic [NUM_CH-1:0]            cond_valid,
    input  logic [NUM_CH-1:0][TW-1:0]    cond_time,
    input  logic [NUM_CH-1:0]            det_high,
    output logic [NUM_CH-1:0]            gate_off
);
    logic [TW-1:0] thr;

    lgm_thresh_sel #(.TW(TW), .LF_THR(LF_THR), .HF_THR(HF_THR)) u_thr (
        .hf_sel (hf_sel),
        .thr    (thr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic idle_fire;

        lgm_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
            .clk      (clk),
            .rst_n    (rst_n),
            .det_high (det_high[c]),
            .fire     (idle_fire)
        );

        lgm_run_fsm #(.TW(TW), .RUN_LEN(RUN_LEN)) u_run (
            .clk        (clk),
            .rst_n      (rst_n),
            .meas_valid (cond_valid[c]),
            .meas_time  (cond_time[c]),
            .thr        (thr),
            .idle_fire  (idle_fire),
            .gate_off   (gate_off[c])
        );
    end
endmodule

// File: rtl/lgm_detector_chk.sv
module lgm_detector_chk #(
    parameter int NUM_CH = 2,
    parameter int TW     = 12,
    parameter int LF_THR = 750,
    parameter int HF_THR = 380
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      hf_sel,
    input logic [NUM_CH-1:0]         cond_valid,
    input logic [NUM_CH-1:0][TW-1:0] cond_time,
    input logic [NUM_CH-1:0]         det_high,
    input logic [NUM_CH-1:0]         gate_off
);
    logic [TW-1:0] ref_thr;
    assign ref_thr = hf_sel ? TW'(HF_THR) : TW'(LF_THR);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R3
        rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_off[c]) |-> ($past(cond_valid[c]) || $past(det_high[c])));

        // R2
        rise_on_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(gate_off[c]) && !$past(det_high[c])) |-> ($past(cond_time[c]) < $past(ref_thr)));

        // R5
        fall_on_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gate_off[c]) |-> ($past(cond_valid[c]) && ($past(cond_time[c]) >= $past(ref_thr))));

        // R10
        quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(cond_valid[c]) && !$past(det_high[c])) |-> $stable(gate_off[c]));
    end
endmodule

bind lgm_detector lgm_detector_chk #(
    .NUM_CH (NUM_CH),
    .TW     (TW),
    .LF_THR (LF_THR),
    .HF_THR (HF_THR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hf_sel     (hf_sel),
    .cond_valid (cond_valid),
    .cond_time  (cond_time),
    .det_high   (det_high),
    .gate_off   (gate_off)
);

// File: tb/lgm_detector_test.sv
module lgm_detector_test;
    localparam int NUM_CH   = 2;
    localparam int TW       = 12;
    localparam int LF_THR   = 750;
    localparam int HF_THR   = 380;
    localparam int RUN_LEN  = 7;
    localparam int IDLE_CYC = 4800;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      hf_sel = 1'b0;
    logic [NUM_CH-1:0]         cond_valid = '0;
    logic [NUM_CH-1:0][TW-1:0] cond_time = '0;
    logic [NUM_CH-1:0]         det_high = '0;
    logic [NUM_CH-1:0]         gate_off;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    lgm_detector #(
        .NUM_CH(NUM_CH), .TW(TW), .LF_THR(LF_THR), .HF_THR(HF_THR),
        .RUN_LEN(RUN_LEN), .IDLE_CYC(IDLE_CYC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .hf_sel(hf_sel), .cond_valid(cond_valid),
        .cond_time(cond_time), .det_high(det_high), .gate_off(gate_off)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic pulse(input int ch, input int t);
        @(negedge clk);
        cond_valid[ch] = 1'b1;
        cond_time[ch]  = TW'(t);
        @(negedge clk);
        cond_valid[ch] = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulses(input int ch, input int n, input int t);
        for (int i = 0; i < n; i++) pulse(ch, t);
    endtask

    task automatic t_reset();
        check("R1 ch0 after reset", gate_off[0], 1'b0);
        check("R1 ch1 after reset", gate_off[1], 1'b0);
    endtask

    task automatic t_enter_exit_lf();
        hf_sel = 1'b0;
        pulses(0, RUN_LEN - 1, 700);
        check("R3 six short not enough", gate_off[0], 1'b0);
        pulse(0, 700);
        check("R3 seventh short enters", gate_off[0], 1'b1);
        check("R9 ch1 untouched", gate_off[1], 1'b0);
        pulses(0, RUN_LEN - 1, LF_THR);
        check("R5 six long at threshold not enough", gate_off[0], 1'b1);
        pulse(0, 100);
        check("R6 short while suspended", gate_off[0], 1'b1);
        pulses(0, RUN_LEN - 1, LF_THR);
        check("R6 run restarted after short", gate_off[0], 1'b1);
        pulse(0, LF_THR);
        check("R5 seventh long exits, equal counts long (R2)", gate_off[0], 1'b0);
    endtask

    task automatic t_run_break();
        pulses(0, 5, 200);
        pulse(0, 800);
        pulses(0, RUN_LEN - 1, 200);
        check("R4 long restarts entry run", gate_off[0], 1'b0);
        pulse(0, 200);
        check("R4 full run after break enters", gate_off[0], 1'b1);
        pulses(0, RUN_LEN, 900);
        check("R5 exit after break test", gate_off[0], 1'b0);
    endtask

    task automatic t_hf();
        hf_sel = 1'b1;
        pulses(0, RUN_LEN, 500);
        check("R2 500 is long in high range", gate_off[0], 1'b0);
        pulses(0, RUN_LEN, HF_THR - 1);
        check("R2 just below high threshold enters", gate_off[0], 1'b1);
        pulses(0, RUN_LEN, HF_THR);
        check("R2 high threshold value exits", gate_off[0], 1'b0);
        hf_sel = 1'b0;
    endtask

    task automatic t_gaps();
        pulses(0, 3, 300);
        repeat (20) @(negedge clk);
        pulses(0, 3, 300);
        check("R10 gaps keep run, not yet", gate_off[0], 1'b0);
        repeat (15) @(negedge clk);
        pulse(0, 300);
        check("R10 gaps do not break run", gate_off[0], 1'b1);
        repeat (30) @(negedge clk);
        check("R10 quiet cycles hold flag", gate_off[0], 1'b1);
        pulses(0, RUN_LEN, 1000);
        check("R5 exit after gap test", gate_off[0], 1'b0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        det_high[1] = 1'b1;
        repeat (IDLE_CYC - 2) @(posedge clk);
        @(negedge clk);
        det_high[1] = 1'b0;
        @(negedge clk);
        det_high[1] = 1'b1;
        repeat (IDLE_CYC - 1) @(posedge clk);
        @(negedge clk);
        check("R7 low sample restarts and one edge short", gate_off[1], 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R7 idle limit enters", gate_off[1], 1'b1);
        check("R9 ch0 unaffected by idle", gate_off[0], 1'b0);
        det_high[1] = 1'b0;
        pulses(1, RUN_LEN - 1, 1200);
        check("R8 six long after idle not enough", gate_off[1], 1'b1);
        pulse(1, 1200);
        check("R8 seventh long clears idle entry", gate_off[1], 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enter_exit_lf();
        t_run_break();
        t_hf();
        t_gaps();
        t_idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule